// File: doc/BRIEF.md
# Maximum Frame Length Enforcer

This block sits in a receive byte path directly after the start-of-frame delimiter has been stripped. It counts every byte of the frame from the first byte after the delimiter to the end-of-frame strobe. It compares that count against a programmable ceiling, which is typically 1518.

Bytes up to the ceiling are passed on unchanged one cycle later. Bytes beyond it are dropped, but the frame is still followed to its real end. When that end arrives, the block emits a one-cycle status record for the frame's closing descriptor. The record holds the frame length and a long-frame flag. For a truncated frame, the length in the record is clamped to the ceiling.

The ceiling is captured on the first byte of each frame. Software can therefore change it at any time without disturbing a frame that is already in progress.

Top module: `mfl_enforcer`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_valid`, `out_last` and `stat_valid` are low.
- R2: Byte number k (counting from 1) of a frame whose captured ceiling is M appears on `out_data` with `out_valid` high exactly one cycle after it is accepted, provided k <= M.
- R3: Any byte with k > M is dropped: `out_valid` stays low in the cycle where it would have appeared.
- R4: `out_last` is high exactly one cycle after a byte accepted with `in_last`. `out_valid` is high in that cycle if that byte was forwarded and low if it was dropped. A truncated frame therefore ends with a data-less end marker.
- R5: `stat_valid` pulses for exactly one cycle per frame, in the same cycle as `out_last`, and at no other time.
- R6: `stat_len` equals the frame length L when L <= M, and equals M when L > M.
- R7: `stat_long` is 1 exactly when L > M, and 0 otherwise.
- R8: `max_len` is sampled with the first byte of a frame. Changes made during the rest of the frame do not alter that frame's forwarding, length or flag.
- R9: A new frame starts at the first accepted byte after reset or after a byte carrying `in_last`. Frames may follow back to back with no idle cycle, and the count and flag restart for each one.
- R10: A cycle with `in_valid` low has no effect. `in_last` and `in_data` are ignored in such a cycle, and the next cycle shows no output activity.

Assertions check R2, R3, R5, R6 and R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| max_len | input | LEN_W | Programmable ceiling on in-frame bytes |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | DATA_W | Input byte |
| in_last | input | 1 | Marks the final byte of the frame (qualified by in_valid) |
| out_valid | output | 1 | Forwarded byte strobe |
| out_data | output | DATA_W | Forwarded byte |
| out_last | output | 1 | End of frame, with or without data |
| stat_valid | output | 1 | Status record strobe |
| stat_len | output | LEN_W | Reported frame length, clamped to the ceiling |
| stat_long | output | 1 | Frame exceeded the ceiling |

## Verification
A wrong byte count or a wrong captured ceiling shows up at the ports in the first cycle where a byte is wrongly forwarded or wrongly dropped. That is at most one cycle after the byte that crosses the ceiling. A count that was not cleared between frames becomes visible on the next frame's first forwarded bytes, and again in its status record, one cycle after that frame's last byte. The bench sweeps every frame length from 1 to 9 against every ceiling from 0 to 6, mixes back-to-back and gapped frames, and changes the ceiling mid-frame. It also runs frames of exactly the typical ceiling and one or two bytes past it. Every output beat is compared against arithmetic on k, L and M.

// File: rtl/mfl_pkg.sv
package mfl_pkg;

    // Per-byte decision handed from the counter to the output stages
    typedef struct packed {
        logic fwd;   // accepted byte lies within the ceiling
        logic eof;   // accepted byte closes the frame
        logic over;  // accepted byte lies beyond the ceiling
    } beat_dec_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BODY = 1'b1
    } frm_state_e;

    // Length reported for a frame: clamped to the ceiling
    function automatic logic [31:0] clamp_len(input logic [31:0] n,
                                              input logic [31:0] lim);
        return (n > lim) ? lim : n;
    endfunction

endpackage

// File: rtl/mfl_counter.sv
module mfl_counter
    import mfl_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] max_len,
    input  logic             in_valid,
    input  logic             in_last,
    output beat_dec_t        dec,
    output logic [LEN_W-1:0] len_now,
    output logic [LEN_W-1:0] lim_now
);
    localparam int CW = LEN_W + 1;

    frm_state_e       st_q;
    logic [CW-1:0]    cnt_q;
    logic [LEN_W-1:0] lim_q;

    logic             first;
    logic [LEN_W-1:0] lim_eff;
    logic [CW-1:0]    lim_ext;
    logic [CW-1:0]    cnt_base;
    logic [CW-1:0]    cnt_next;
    logic             over;

    always_comb begin
        first    = in_valid && (st_q == ST_IDLE);
        lim_eff  = first ? max_len : lim_q;
        lim_ext  = {1'b0, lim_eff};
        cnt_base = first ? '0 : cnt_q;
        // the byte being accepted is number cnt_base+1
        over     = (cnt_base >= lim_ext);
        cnt_next = over ? (lim_ext + CW'(1)) : (cnt_base + CW'(1));
        len_now  = over ? lim_eff : cnt_next[LEN_W-1:0];
        lim_now  = lim_eff;
        dec.fwd  = in_valid && !over;
        dec.over = in_valid && over;
        dec.eof  = in_valid && in_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            lim_q <= '0;
        end else if (in_valid) begin
            cnt_q <= cnt_next;
            lim_q <= lim_eff;
            st_q  <= in_last ? ST_IDLE : ST_BODY;
        end
    end

    // R6: stored count never runs past one above the captured ceiling
    p_count_sat_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_BODY) |-> (cnt_q <= ({1'b0, lim_q} + CW'(1))));

endmodule

// File: rtl/mfl_gate.sv
module mfl_gate
    import mfl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  beat_dec_t         dec,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= dec.fwd;
            out_data  <= dec.fwd ? in_data : '0;
            out_last  <= dec.eof;
        end
    end

    // R3: a byte judged beyond the ceiling never surfaces
    p_drop_r3: assert property (@(posedge clk) disable iff (rst)
        $past(dec.over) |-> !out_valid);

endmodule

// File: rtl/mfl_status.sv
module mfl_status
    import mfl_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  beat_dec_t        dec,
    input  logic [LEN_W-1:0] len_now,
    input  logic [LEN_W-1:0] lim_now,
    output logic             stat_valid,
    output logic [LEN_W-1:0] stat_len,
    output logic             stat_long
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_valid <= 1'b0;
            stat_len   <= '0;
            stat_long  <= 1'b0;
        end else if (dec.eof) begin
            stat_valid <= 1'b1;
            stat_len   <= len_now;
            stat_long  <= dec.over;
        end else begin
            stat_valid <= 1'b0;
            stat_len   <= '0;
            stat_long  <= 1'b0;
        end
    end

    // R6: a long frame reports exactly the captured ceiling
    p_long_len_r6: assert property (@(posedge clk) disable iff (rst)
        (stat_valid && stat_long) |-> (stat_len == $past(lim_now)));

endmodule

// File: rtl/mfl_enforcer.sv
module mfl_enforcer
    import mfl_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LEN_W-1:0]  max_len,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              stat_valid,
    output logic [LEN_W-1:0]  stat_len,
    output logic              stat_long
);
    beat_dec_t        dec;
    logic [LEN_W-1:0] len_now;
    logic [LEN_W-1:0] lim_now;

    mfl_counter #(.LEN_W(LEN_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .max_len  (max_len),
        .in_valid (in_valid),
        .in_last  (in_last),
        .dec      (dec),
        .len_now  (len_now),
        .lim_now  (lim_now)
    );

    mfl_gate #(.DATA_W(DATA_W)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .dec       (dec),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    mfl_status #(.LEN_W(LEN_W)) u_stat (
        .clk        (clk),
        .rst        (rst),
        .dec        (dec),
        .len_now    (len_now),
        .lim_now    (lim_now),
        .stat_valid (stat_valid),
        .stat_len   (stat_len),
        .stat_long  (stat_long)
    );

    // R5: status record and end marker coincide
    p_stat_last_r5: assert property (@(posedge clk) disable iff (rst)
        stat_valid == out_last);

    // R10: an idle input cycle leaves the outputs quiet
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) |-> (!out_valid && !out_last && !stat_valid));

    // R2: forwarded data is the byte accepted one cycle earlier
    p_fwd_data_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(in_valid) && out_data == $past(in_data)));

endmodule

// File: tb/sim_mfl_enforcer.sv
module sim_mfl_enforcer;
    localparam int LEN_W  = 16;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [LEN_W-1:0]  max_len = '0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_last = 1'b0;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;
    logic              out_last;
    logic              stat_valid;
    logic [LEN_W-1:0]  stat_len;
    logic              stat_long;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    mfl_enforcer #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst(rst), .max_len(max_len),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .stat_valid(stat_valid), .stat_len(stat_len), .stat_long(stat_long)
    );

    task automatic chk(input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic quiet(input string req);
        chk(req, "out_valid", int'(out_valid), 0);
        chk(req, "out_last", int'(out_last), 0);
        chk(req, "stat_valid", int'(stat_valid), 0);
    endtask

    // Sends one frame of length l with ceiling m; chg moves max_len after byte 1
    task automatic send_frame(input int m, input int l, input int gap, input bit chg);
        for (int i = 1; i <= l; i++) begin
            logic [7:0] b;
            b = 8'((l * 16) + (i * 7) + m);
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = b;
            in_last  = (i == l);
            if (i == 1) max_len = LEN_W'(m);
            else if (chg) max_len = LEN_W'((m + i) % 4); // R8: mid-frame change
            @(posedge clk);
            #1;
            if (i <= m) begin
                chk("R2", "out_valid", int'(out_valid), 1);
                chk("R2", "out_data", int'(out_data), int'(b));
            end else begin
                chk("R3", "out_valid", int'(out_valid), 0);
            end
            chk("R4", "out_last", int'(out_last), int'(i == l));
            chk("R5", "stat_valid", int'(stat_valid), int'(i == l));
            if (i == l) begin
                chk(chg ? "R8" : "R6", "stat_len", int'(stat_len),
                    int'(mfl_pkg::clamp_len(32'(l), 32'(m))));
                chk(chg ? "R8" : "R7", "stat_long", int'(stat_long), int'(l > m));
            end
        end
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b1;     // R10: ignored without in_valid
            in_data  = 8'hA5;
            @(posedge clk);
            #1;
            quiet("R10");
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        quiet("R1");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        quiet("R1");

        // R9: sweep with back-to-back (gap 0) and gapped frames
        for (int m = 0; m <= 6; m++) begin
            for (int l = 1; l <= 9; l++) begin
                send_frame(m, l, (l + m) % 2, 1'b0);
            end
        end
        // R8: ceiling moves during the frame
        for (int l = 2; l <= 9; l++) begin
            send_frame(5, l, 1, 1'b1);
        end
        // typical ceiling at and past the boundary
        send_frame(1518, 1518, 1, 1'b0);
        send_frame(1518, 1519, 0, 1'b0);
        send_frame(1518, 1520, 1, 1'b0);
        send_frame(3, 2, 2, 1'b0);

        done = 1'b1;
        finish_run();
    end

endmodule